// File: doc/BRIEF.md
# Serial Control-Port Slave with Interrupt Status

This block is the register-access port of a radio receiver. A host microcontroller drives a four-wire serial link: an active-low select, a serial clock, a data line into the block and a data line out of it. Each transaction is a 16-bit command frame sent most significant bit first. The upper byte is a command code and the lower byte carries that command's parameter field, whose width depends on the command. A frame changes a control register only if exactly 16 bits were clocked in when the select line is released. All link pins are sampled by the block's own clock through synchronizers. The serial clock must therefore run well below the system clock.

While a frame is clocked in, the block returns a 16-bit status word on the data-out line. That word is captured when the select line falls. Four event inputs set sticky interrupt flags: low supply, wake-up timeout, FIFO threshold and FIFO overflow. An active-low interrupt output is asserted while any flag is set. The host finds the cause by reading the status word. A complete status-read frame clears the flags that the word reported.

Top module: `spi_ctrl_slave`

## Requirements
- R1: While the synchronized select is low, each rising edge of the serial clock shifts one data-in bit into the frame, MSB first. The code is taken from frame bits 15:8 and the parameter field from bits 7:0.
- R2: A high select clears the bit count and the input shift state, so every frame starts from bit 15 again.
- R3: A register is written only when select rises after exactly 16 clocked bits. A frame of 8 or 24 bits leaves every register unchanged.
- R4: The status word is placed on data-out MSB first. Bit 15 is present from the select fall, and the line advances one bit after each falling serial-clock edge.
- R5: The data-out enable is low whenever select is high, so the pad is high-impedance.
- R6: After reset, the registers hold their defaults: configuration 0x00, FIFO threshold 0x8, supply threshold 0x00, wake period 0x96.
- R7: The command codes and their fields are as follows. 0x80 loads configuration from bits 7:0. 0xCE loads the FIFO threshold from bits 3:0. 0xC2 loads the supply threshold from bits 4:0. 0xE0 loads the wake period from bits 7:0. Any other code writes nothing.
- R8: Each event input pulse sets a sticky flag. The interrupt output is low while any flag is set.
- R9: FIFO-threshold and FIFO-overflow events are ignored while configuration bit 0 (FIFO enable) is 0.
- R10: The status word is laid out as follows. Bit 15 is low supply, bit 14 is wake timeout, bit 13 is FIFO threshold and bit 12 is FIFO overflow. Bits 11:8 are zero and bits 7:0 are the configuration.
- R11: A complete 16-bit frame with code 0x00 clears, at the select rise, the flags shown in its status word. A partial read clears nothing. An event that arrives during the read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| csn_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Data-out pad enable; low means high-impedance |
| lbd_evt_i | input | 1 | Low-supply event pulse |
| wake_evt_i | input | 1 | Wake-up timeout pulse |
| ffit_evt_i | input | 1 | FIFO threshold reached pulse |
| ffov_evt_i | input | 1 | FIFO overflow pulse |
| nirq_o | output | 1 | Interrupt request, active low |
| cfg_o | output | 8 | Configuration register; bit 0 enables the FIFO |
| fifo_thr_o | output | 4 | FIFO threshold register |
| lbd_thr_o | output | 5 | Supply threshold register |
| wake_per_o | output | 8 | Wake period register |

## Verification
Several rules are checked by assertions on every cycle:
- a high select clears the bit count, and each serial clock rise advances it by one;
- the data-out bit changes only at a select fall or a serial-clock fall;
- registers change only on a write strobe, and never on an unknown code;
- flags stay set until a clear, masked FIFO flags stay low, and a clear removes every flag that was reported and not re-triggered.

Other behaviour needs the bench's scenarios. These include the exact-length framing at the ports, the bit order and layout of the returned status word, and the power-on values. They also include partial reads that clear nothing and an event arriving in the middle of a status read.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_W = 16;
  localparam int CODE_W  = 8;
  localparam int DATA_W  = FRAME_W - CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W) + 2;
  localparam int IRQ_N   = 4;
  localparam int CFG_W   = 8;
  localparam int FTHR_W  = 4;
  localparam int LTHR_W  = 5;
  localparam int WAKE_W  = 8;

  localparam logic [CFG_W-1:0]  CFG_RST  = 8'h00;
  localparam logic [FTHR_W-1:0] FTHR_RST = 4'h8;
  localparam logic [LTHR_W-1:0] LTHR_RST = 5'h00;
  localparam logic [WAKE_W-1:0] WAKE_RST = 8'h96;

  // flag indices; also status bit order from the top
  localparam int IRQ_LBD  = 3;
  localparam int IRQ_WAKE = 2;
  localparam int IRQ_FFIT = 1;
  localparam int IRQ_FFOV = 0;

  typedef enum logic [CODE_W-1:0] {
    CMD_STATUS = 8'h00,
    CMD_CFG    = 8'h80,
    CMD_FTHR   = 8'hCE,
    CMD_LTHR   = 8'hC2,
    CMD_WAKE   = 8'hE0
  } cmd_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csn_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               sdo_o,
  output logic               sdo_en_o,
  output logic               start_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [2:0] pins_s;
  logic       csn_s, sck_s, sdi_s;
  logic       csn_q, sck_q;
  logic       sck_rise, sck_fall, cs_fall, cs_rise;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] in_q, out_q;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sck_i, sdi_i}),
    .q_o   (pins_s)
  );
  assign {csn_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_fall  = csn_q & ~csn_s;
  assign cs_rise  = ~csn_q & csn_s;

  // input side: count and shift on serial clock rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      in_q  <= '0;
    end else if (csn_s) begin
      cnt_q <= '0;
      in_q  <= '0;
    end else if (sck_rise) begin
      in_q <= {in_q[FRAME_W-2:0], sdi_s};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // output side: load at select fall, advance on serial clock fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else if (cs_fall) out_q <= status_i;
    else if (sck_fall && !csn_s) out_q <= {out_q[FRAME_W-2:0], 1'b0};
  end

  assign sdo_o    = out_q[FRAME_W-1];
  assign sdo_en_o = ~csn_s;
  assign start_o  = cs_fall;
  assign done_o   = cs_rise && (cnt_q == CNT_FULL);
  assign frame_o  = in_q;

  p_cnt_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> (cnt_q == '0));

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && !csn_s && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_sdo_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall && !cs_fall) |=> $stable(sdo_o));

  p_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |-> !sdo_en_o);
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [FTHR_W-1:0]  fthr_o,
  output logic [LTHR_W-1:0]  lthr_o,
  output logic [WAKE_W-1:0]  wake_o
);
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] data;
  logic              known;
  logic              unused_bits;

  assign code = frame_i[FRAME_W-1 -: CODE_W];
  assign data = frame_i[DATA_W-1:0];
  assign unused_bits = ^data[DATA_W-1:LTHR_W];

  always_comb begin
    unique case (code)
      CMD_CFG, CMD_FTHR, CMD_LTHR, CMD_WAKE: known = 1'b1;
      default:                               known = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= CFG_RST;
      fthr_o <= FTHR_RST;
      lthr_o <= LTHR_RST;
      wake_o <= WAKE_RST;
    end else if (wr_i) begin
      unique case (code)
        CMD_CFG:  cfg_o  <= data[CFG_W-1:0];
        CMD_FTHR: fthr_o <= data[FTHR_W-1:0];
        CMD_LTHR: lthr_o <= data[LTHR_W-1:0];
        CMD_WAKE: wake_o <= data[WAKE_W-1:0];
        default: ;
      endcase
    end
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({cfg_o, fthr_o, lthr_o, wake_o}));

  p_unknown_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !known) |=> $stable({cfg_o, fthr_o, lthr_o, wake_o}));
endmodule

// File: rtl/spi_irq.sv
module spi_irq
  import spi_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_N-1:0] evt_i,
  input  logic             fifo_en_i,
  input  logic             snap_i,
  input  logic             clr_i,
  output logic [IRQ_N-1:0] flags_o,
  output logic             nirq_o
);
  logic [IRQ_N-1:0] mask, set, flags_q, snap_q;

  always_comb begin
    mask = '1;
    mask[IRQ_FFIT] = fifo_en_i;
    mask[IRQ_FFOV] = fifo_en_i;
  end

  assign set = evt_i & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      snap_q  <= '0;
    end else begin
      if (snap_i) snap_q <= flags_q;
      flags_q <= (flags_q & ~(clr_i ? snap_q : '0)) | set;
    end
  end

  assign flags_o = flags_q;
  assign nirq_o  = ~|flags_q;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_chk
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[i] && !clr_i) |=> flags_q[i]);
    p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && snap_q[i] && !evt_i[i]) |=> !flags_q[i]);
  end

  p_mask_ffit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !flags_q[IRQ_FFIT]) |=> !flags_q[IRQ_FFIT]);
  p_mask_ffov_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !flags_q[IRQ_FFOV]) |=> !flags_q[IRQ_FFOV]);
endmodule

// File: rtl/spi_ctrl_slave.sv
module spi_ctrl_slave
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  input  logic              lbd_evt_i,
  input  logic              wake_evt_i,
  input  logic              ffit_evt_i,
  input  logic              ffov_evt_i,
  output logic              nirq_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [FTHR_W-1:0] fifo_thr_o,
  output logic [LTHR_W-1:0] lbd_thr_o,
  output logic [WAKE_W-1:0] wake_per_o
);
  logic               start, done, rd_done;
  logic [FRAME_W-1:0] frame, status;
  logic [IRQ_N-1:0]   flags, evts;

  assign evts = {lbd_evt_i, wake_evt_i, ffit_evt_i, ffov_evt_i};
  assign status = {flags, {(FRAME_W-IRQ_N-CFG_W){1'b0}}, cfg_o};
  assign rd_done = done && (frame[FRAME_W-1 -: CODE_W] == CMD_STATUS);

  spi_frame #(.SYNC_STAGES(SYNC_STAGES)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .csn_i   (csn_i),
    .sck_i   (sck_i),
    .sdi_i   (sdi_i),
    .status_i(status),
    .sdo_o   (sdo_o),
    .sdo_en_o(sdo_en_o),
    .start_o (start),
    .done_o  (done),
    .frame_o (frame)
  );

  spi_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (done),
    .frame_i(frame),
    .cfg_o  (cfg_o),
    .fthr_o (fifo_thr_o),
    .lthr_o (lbd_thr_o),
    .wake_o (wake_per_o)
  );

  spi_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evts),
    .fifo_en_i(cfg_o[0]),
    .snap_i   (start),
    .clr_i    (rd_done),
    .flags_o  (flags),
    .nirq_o   (nirq_o)
  );
endmodule

// File: tb/sim_spi_ctrl_slave.sv
`timescale 1ns/1ps
module sim_spi_ctrl_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic lbd = 1'b0, wake = 1'b0, ffit = 1'b0, ffov = 1'b0;
  logic sdo, sdo_en, nirq;
  logic [7:0] cfg, wper;
  logic [3:0] fthr;
  logic [4:0] lthr;
  int n_vec = 0, n_err = 0;
  bit done = 1'b0;
  logic [23:0] rd;

  always #2.5 clk = ~clk;

  spi_ctrl_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .lbd_evt_i(lbd), .wake_evt_i(wake),
    .ffit_evt_i(ffit), .ffov_evt_i(ffov), .nirq_o(nirq), .cfg_o(cfg),
    .fifo_thr_o(fthr), .lbd_thr_o(lthr), .wake_per_o(wper)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    case (idx)
      3: lbd = 1'b1;
      2: wake = 1'b1;
      1: ffit = 1'b1;
      default: ffov = 1'b1;
    endcase
    @(negedge clk);
    {lbd, wake, ffit, ffov} = '0;
    wait_clk(3);
  endtask

  // evt_at: bit index after which event evt_idx is pulsed, -1 for none
  task automatic xfer(input logic [23:0] word, input int nbits,
                      input int evt_at, input int evt_idx);
    rd = '0;
    csn = 1'b0;
    wait_clk(10);
    for (int b = 0; b < nbits; b++) begin
      sdi = word[nbits-1-b];
      wait_clk(10);
      if (b == 0) check("R5 enable during frame", 32'(sdo_en), 32'd1);
      rd = {rd[22:0], sdo};
      if (b == evt_at) pulse(evt_idx);
      sck = 1'b1;
      wait_clk(10);
      sck = 1'b0;
    end
    wait_clk(10);
    csn = 1'b1;
    wait_clk(10);
  endtask

  task automatic regs_are(input string req, input logic [7:0] c, input logic [3:0] f,
                          input logic [4:0] l, input logic [7:0] w);
    check(req, {cfg, fthr, lthr, wper, 7'd0}, {c, f, l, w, 7'd0});
  endtask

  task automatic t_reset;
    regs_are("R6 defaults", 8'h00, 4'h8, 5'h00, 8'h96);
    check("R8 nirq idle", 32'(nirq), 32'd1);
    check("R5 hi-z idle", 32'(sdo_en), 32'd0);
  endtask

  task automatic t_writes;
    xfer(24'h0080_81, 16, -1, 0);
    xfer(24'h00CE_5A, 16, -1, 0);
    xfer(24'h00C2_FF, 16, -1, 0);
    xfer(24'h00E0_12, 16, -1, 0);
    regs_are("R1 R7 writes", 8'h81, 4'hA, 5'h1F, 8'h12);
    check("R5 hi-z after frame", 32'(sdo_en), 32'd0);
  endtask

  task automatic t_bad_frames;
    xfer(24'h0055_AB, 16, -1, 0);
    regs_are("R7 unknown code", 8'h81, 4'hA, 5'h1F, 8'h12);
    xfer(24'h0000_CE, 8, -1, 0);
    regs_are("R3 short frame", 8'h81, 4'hA, 5'h1F, 8'h12);
    xfer(24'hE0_34_56, 24, -1, 0);
    regs_are("R3 long frame", 8'h81, 4'hA, 5'h1F, 8'h12);
    xfer(24'h00E0_77, 16, -1, 0);
    regs_are("R2 fresh frame after partial", 8'h81, 4'hA, 5'h1F, 8'h77);
  endtask

  task automatic t_mask;
    xfer(24'h0080_00, 16, -1, 0);
    pulse(1);
    pulse(0);
    check("R9 masked fifo events", 32'(nirq), 32'd1);
    xfer(24'h0000_00, 16, -1, 0);
    check("R9 R10 status masked", 32'(rd[15:0]), 32'h0000);
    xfer(24'h0080_01, 16, -1, 0);
  endtask

  task automatic t_source(input int idx, input logic [15:0] exp);
    pulse(idx);
    check("R8 nirq asserted", 32'(nirq), 32'd0);
    xfer(24'h0000_00, 16, -1, 0);
    check("R4 R10 status word", 32'(rd[15:0]), 32'(exp));
    check("R11 nirq released", 32'(nirq), 32'd1);
  endtask

  task automatic t_partial_read;
    pulse(3);
    xfer(24'h0000_00, 8, -1, 0);
    check("R4 partial read top byte", 32'(rd[7:0]), 32'h80);
    check("R11 partial read keeps flag", 32'(nirq), 32'd0);
    xfer(24'h0000_00, 16, -1, 0);
    check("R11 full read clears", 32'(nirq), 32'd1);
  endtask

  task automatic t_mid_read;
    pulse(3);
    xfer(24'h0000_00, 16, 8, 2);
    check("R10 snapshot word", 32'(rd[15:0]), 32'h8001);
    check("R11 late event kept", 32'(nirq), 32'd0);
    xfer(24'h0000_00, 16, -1, 0);
    check("R11 late event reported", 32'(rd[15:0]), 32'h4001);
    check("R11 cleared after second read", 32'(nirq), 32'd1);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_writes();
    t_bad_frames();
    t_mask();
    t_source(3, 16'h8001);
    t_source(2, 16'h4001);
    t_source(1, 16'h2001);
    t_source(0, 16'h1001);
    t_partial_read();
    t_mid_read();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule